// File: doc/BRIEF.md
# Four-Level Page Table Walker

This block handles translation misses. It takes a 48-bit virtual address and a set of access attributes: write, user mode and instruction fetch. It then walks a four-level radix tree of 64-bit entries in memory, starting from a root table page number, and returns either a 40-bit physical page number with the joined 52-bit physical address, or a fault code. Each level takes one read over a single-outstanding request/acknowledge memory port.

Each visited entry is checked against the access as soon as it is read. A missing entry, or a missing right at any level, ends the walk at once. A walk that passes all four levels then enters an update phase. The phase runs from the top level to the leaf and writes back only those entries whose accessed flag, or the leaf's dirty flag, has to change. A faulting walk therefore never modifies memory.

Top module: `ptw_walker`

## Requirements
- R1: Level k (k = 0 for the top table) reads the entry at address {base, idx_k, 3'b000}. idx_k is the 9-bit field vaddr_i[47-9k -: 9], and base is root_ppn_i at level 0 and bits [51:12] of the previous level's entry otherwise. Reads are issued in order from level 0 to level 3.
- R2: After a successful walk, ppn_o equals bits [51:12] of the level-3 entry and paddr_o equals {ppn_o, vaddr_i[11:0]}.
- R3: An entry with bit 0 (present) clear ends the walk with fault_code_o = 1 (not present), and no further level is read.
- R4: A write access faults with fault_code_o = 2 (protection) if bit 1 (writable) is clear in any visited entry. A read access with the same entries succeeds.
- R5: A user access faults with code 2 if bit 2 (user-allowed) is clear in any visited entry. A supervisor access with the same entries succeeds.
- R6: An instruction fetch faults with code 2 if bit 63 (no-execute) is set in any visited entry, whether leaf or upper level. A data read with the same entries succeeds.
- R7: On a successful walk, bit 5 (accessed) ends up set in all four visited entries. Write-backs are issued from level 0 down to level 3.
- R8: On a successful write access, bit 6 (dirty) is set in the level-3 entry only, and upper-level entries keep bit 6 unchanged.
- R9: An entry is written back only when its accessed or dirty bit changes. A faulting walk writes nothing, and all write-backs follow the last read.
- R10: done_o is a one-cycle pulse that ends each walk. fault_code_o is 0 on success, and ppn_o is 0 on a fault. Results hold until the next walk is accepted.
- R11: At most one memory request is outstanding. mem_req_o is a one-cycle pulse, and no new request is issued until mem_ack_i has returned. No request is made while idle_o is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Start a walk (taken when idle_o is high) |
| idle_o | output | 1 | Walker is ready for a new walk |
| root_ppn_i | input | 40 | Page number of the top-level table |
| vaddr_i | input | 48 | Virtual address to translate |
| acc_write_i | input | 1 | Access is a write |
| acc_user_i | input | 1 | Access is from user mode |
| acc_fetch_i | input | 1 | Access is an instruction fetch |
| mem_req_o | output | 1 | One-cycle memory request pulse |
| mem_we_o | output | 1 | Request is an entry write-back |
| mem_addr_o | output | 52 | Byte address of the entry |
| mem_wdata_o | output | 64 | Updated entry for a write-back |
| mem_ack_i | input | 1 | Request completed (read data valid for reads) |
| mem_rdata_i | input | 64 | Entry read from memory |
| done_o | output | 1 | Walk finished (one cycle) |
| fault_code_o | output | 2 | 0 none, 1 not present, 2 protection |
| ppn_o | output | 40 | Translated physical page number |
| paddr_o | output | 52 | Translated physical address |

## Verification
Each result has its own due time. The first request appears one cycle after acceptance. Each later request appears one cycle after the acknowledge of the previous one. done_o pulses one cycle after the last acknowledge, or one cycle after the last skipped write-back check. Because the memory model's latency changes from walk to walk, the scoreboard does not count cycles. Its monitor samples on the falling edge and compares the fault code, page number and address in exactly the cycle done_o is high. The driver inspects the model's memory and its logs of read and write addresses only after that pulse, when the walk's final effects are due.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
  localparam int unsigned BIT_P  = 0;
  localparam int unsigned BIT_RW = 1;
  localparam int unsigned BIT_US = 2;
  localparam int unsigned BIT_A  = 5;
  localparam int unsigned BIT_D  = 6;
  localparam int unsigned BIT_XD = 63;

  typedef enum logic [1:0] {
    FLT_NONE        = 2'd0,
    FLT_NOT_PRESENT = 2'd1,
    FLT_PROT        = 2'd2
  } fault_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_RD_REQ, ST_RD_WAIT, ST_WB_CHECK, ST_WB_WAIT, ST_DONE
  } state_e;

  typedef struct packed {
    logic write;
    logic user;
    logic fetch;
  } access_t;
endpackage

// File: rtl/ptw_addr_gen.sv
module ptw_addr_gen #(
  parameter int unsigned LEVELS = 4,
  parameter int unsigned IDX_W  = 9,
  parameter int unsigned OFF_W  = 12,
  parameter int unsigned PPN_W  = 40
) (
  input  logic [PPN_W-1:0]          base_ppn_i,
  input  logic [LEVELS*IDX_W-1:0]   vpn_i,
  input  logic [$clog2(LEVELS)-1:0] level_i,
  output logic [PPN_W+OFF_W-1:0]    addr_o
);
  localparam int unsigned ENT_SH = OFF_W - IDX_W;

  logic [IDX_W-1:0] idx_arr [LEVELS];

  // level 0 takes the most significant index field
  for (genvar g = 0; g < LEVELS; g++) begin : g_idx
    assign idx_arr[g] = vpn_i[(LEVELS-1-g)*IDX_W +: IDX_W];
  end

  assign addr_o = {base_ppn_i, idx_arr[level_i], {ENT_SH{1'b0}}};
endmodule

// File: rtl/ptw_perm_check.sv
module ptw_perm_check
  import ptw_pkg::*;
(
  input  logic    present_i,
  input  logic    writable_i,
  input  logic    user_ok_i,
  input  logic    no_exec_i,
  input  access_t acc_i,
  output fault_e  code_o
);
  always_comb begin
    if (!present_i)
      code_o = FLT_NOT_PRESENT;
    else if ((acc_i.write && !writable_i) ||
             (acc_i.user  && !user_ok_i)  ||
             (acc_i.fetch &&  no_exec_i))
      code_o = FLT_PROT;
    else
      code_o = FLT_NONE;
  end
endmodule

// File: rtl/ptw_update.sv
module ptw_update
  import ptw_pkg::*;
#(
  parameter int unsigned PTE_W = 64
) (
  input  logic [PTE_W-1:0] pte_i,
  input  logic             is_leaf_i,
  input  logic             write_i,
  output logic [PTE_W-1:0] pte_o,
  output logic             changed_o
);
  logic [PTE_W-1:0] set_mask;

  always_comb begin
    set_mask        = '0;
    set_mask[BIT_A] = 1'b1;
    set_mask[BIT_D] = is_leaf_i && write_i;
  end

  assign pte_o     = pte_i | set_mask;
  assign changed_o = (pte_o != pte_i);
endmodule

// File: rtl/ptw_walker.sv
module ptw_walker
  import ptw_pkg::*;
#(
  parameter int unsigned LEVELS = 4,
  parameter int unsigned IDX_W  = 9,
  parameter int unsigned OFF_W  = 12,
  parameter int unsigned PPN_W  = 40,
  parameter int unsigned PTE_W  = 64
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic                            req_valid_i,
  output logic                            idle_o,
  input  logic [PPN_W-1:0]                root_ppn_i,
  input  logic [LEVELS*IDX_W+OFF_W-1:0]   vaddr_i,
  input  logic                            acc_write_i,
  input  logic                            acc_user_i,
  input  logic                            acc_fetch_i,
  output logic                            mem_req_o,
  output logic                            mem_we_o,
  output logic [PPN_W+OFF_W-1:0]          mem_addr_o,
  output logic [PTE_W-1:0]                mem_wdata_o,
  input  logic                            mem_ack_i,
  input  logic [PTE_W-1:0]                mem_rdata_i,
  output logic                            done_o,
  output logic [1:0]                      fault_code_o,
  output logic [PPN_W-1:0]                ppn_o,
  output logic [PPN_W+OFF_W-1:0]          paddr_o
);
  localparam int unsigned PA_W  = PPN_W + OFF_W;
  localparam int unsigned VPN_W = LEVELS * IDX_W;
  localparam int unsigned LVL_W = $clog2(LEVELS);
  localparam logic [LVL_W-1:0] LAST_LVL = LVL_W'(LEVELS - 1);

  state_e            state_q;
  logic [LVL_W-1:0]  lvl_q;
  logic [PTE_W-1:0]  ent_q [LEVELS];
  logic [PPN_W-1:0]  root_q;
  logic [VPN_W-1:0]  vpn_q;
  logic [OFF_W-1:0]  off_q;
  access_t           acc_q;
  fault_e            fault_q;
  logic [PPN_W-1:0]  ppn_q;

  logic [PPN_W-1:0]  base_arr [LEVELS];
  logic [PA_W-1:0]   ent_addr;
  fault_e            chk_code;
  logic [PTE_W-1:0]  upd_pte;
  logic              upd_changed;
  logic              is_last;

  assign is_last = (lvl_q == LAST_LVL);

  assign base_arr[0] = root_q;
  for (genvar g = 1; g < LEVELS; g++) begin : g_base
    assign base_arr[g] = ent_q[g-1][PA_W-1:OFF_W];
  end

  ptw_addr_gen #(
    .LEVELS(LEVELS), .IDX_W(IDX_W), .OFF_W(OFF_W), .PPN_W(PPN_W)
  ) i_addr_gen (
    .base_ppn_i (base_arr[lvl_q]),
    .vpn_i      (vpn_q),
    .level_i    (lvl_q),
    .addr_o     (ent_addr)
  );

  ptw_perm_check i_perm (
    .present_i  (mem_rdata_i[BIT_P]),
    .writable_i (mem_rdata_i[BIT_RW]),
    .user_ok_i  (mem_rdata_i[BIT_US]),
    .no_exec_i  (mem_rdata_i[BIT_XD]),
    .acc_i      (acc_q),
    .code_o     (chk_code)
  );

  ptw_update #(.PTE_W(PTE_W)) i_update (
    .pte_i     (ent_q[lvl_q]),
    .is_leaf_i (is_last),
    .write_i   (acc_q.write),
    .pte_o     (upd_pte),
    .changed_o (upd_changed)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      lvl_q   <= '0;
      root_q  <= '0;
      vpn_q   <= '0;
      off_q   <= '0;
      acc_q   <= '0;
      fault_q <= FLT_NONE;
      ppn_q   <= '0;
      for (int i = 0; i < LEVELS; i++) ent_q[i] <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (req_valid_i) begin
          root_q  <= root_ppn_i;
          vpn_q   <= vaddr_i[PA_W-PPN_W+VPN_W-1:OFF_W];
          off_q   <= vaddr_i[OFF_W-1:0];
          acc_q   <= '{write: acc_write_i, user: acc_user_i, fetch: acc_fetch_i};
          fault_q <= FLT_NONE;
          ppn_q   <= '0;
          lvl_q   <= '0;
          state_q <= ST_RD_REQ;
        end
        ST_RD_REQ: state_q <= ST_RD_WAIT;
        ST_RD_WAIT: if (mem_ack_i) begin
          ent_q[lvl_q] <= mem_rdata_i;
          if (chk_code != FLT_NONE) begin
            fault_q <= chk_code;
            state_q <= ST_DONE;
          end else if (is_last) begin
            ppn_q   <= mem_rdata_i[PA_W-1:OFF_W];
            lvl_q   <= '0;
            state_q <= ST_WB_CHECK;
          end else begin
            lvl_q   <= lvl_q + LVL_W'(1);
            state_q <= ST_RD_REQ;
          end
        end
        ST_WB_CHECK: begin
          if (upd_changed)  state_q <= ST_WB_WAIT;
          else if (is_last) state_q <= ST_DONE;
          else              lvl_q   <= lvl_q + LVL_W'(1);
        end
        ST_WB_WAIT: if (mem_ack_i) begin
          if (is_last) state_q <= ST_DONE;
          else begin
            lvl_q   <= lvl_q + LVL_W'(1);
            state_q <= ST_WB_CHECK;
          end
        end
        ST_DONE: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign idle_o       = (state_q == ST_IDLE);
  assign done_o       = (state_q == ST_DONE);
  assign mem_we_o     = (state_q == ST_WB_CHECK) && upd_changed;
  assign mem_req_o    = (state_q == ST_RD_REQ) || mem_we_o;
  assign mem_addr_o   = ent_addr;
  assign mem_wdata_o  = upd_pte;
  assign fault_code_o = fault_q;
  assign ppn_o        = ppn_q;
  assign paddr_o      = {ppn_q, off_q};
endmodule

// File: rtl/ptw_walker_chk.sv
module ptw_walker_chk #(
  parameter int unsigned LEVELS = 4,
  parameter int unsigned PPN_W  = 40
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             req_valid_i,
  input logic             idle_o,
  input logic             mem_req_o,
  input logic             mem_we_o,
  input logic             wr_present_i,
  input logic             wr_accessed_i,
  input logic             done_o,
  input logic [1:0]       fault_code_o,
  input logic [PPN_W-1:0] ppn_o,
  input logic [PPN_W-1:0] paddr_hi_i
);
  localparam int unsigned CNT_W = $clog2(LEVELS + 1) + 1;

  logic [CNT_W-1:0] rd_cnt_q;
  logic             wrote_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_cnt_q <= '0;
      wrote_q  <= 1'b0;
    end else if (req_valid_i && idle_o) begin
      rd_cnt_q <= '0;
      wrote_q  <= 1'b0;
    end else begin
      if (mem_req_o && !mem_we_o) rd_cnt_q <= rd_cnt_q + CNT_W'(1);
      if (mem_we_o) wrote_q <= 1'b1;
    end
  end

  a_r11_req_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |=> !mem_req_o);
  a_r11_quiet_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idle_o |-> !mem_req_o);
  a_r1_read_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_we_o) |-> rd_cnt_q < CNT_W'(LEVELS));
  a_r10_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  a_r10_fault_no_ppn: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && fault_code_o != 2'd0) |-> ppn_o == '0);
  a_r3_code_legal: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> fault_code_o != 2'd3);
  a_r2_paddr_join: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> paddr_hi_i == ppn_o);
  a_r7_wb_accessed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> (wr_accessed_i && wr_present_i));
  a_r9_wb_after_reads: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> rd_cnt_q == CNT_W'(LEVELS));
  a_r9_no_wb_on_fault: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && fault_code_o != 2'd0) |-> !wrote_q);
endmodule

bind ptw_walker ptw_walker_chk #(.LEVELS(LEVELS), .PPN_W(PPN_W)) i_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .req_valid_i   (req_valid_i),
  .idle_o        (idle_o),
  .mem_req_o     (mem_req_o),
  .mem_we_o      (mem_we_o),
  .wr_present_i  (mem_wdata_o[ptw_pkg::BIT_P]),
  .wr_accessed_i (mem_wdata_o[ptw_pkg::BIT_A]),
  .done_o        (done_o),
  .fault_code_o  (fault_code_o),
  .ppn_o         (ppn_o),
  .paddr_hi_i    (paddr_o[PPN_W+OFF_W-1:OFF_W])
);

// File: tb/test_ptw_walker.sv
module test_ptw_walker;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        idle;
  logic [39:0] root_ppn = '0;
  logic [47:0] vaddr = '0;
  logic        acc_w = 1'b0, acc_u = 1'b0, acc_f = 1'b0;
  logic        mem_req, mem_we;
  logic [51:0] mem_addr;
  logic [63:0] mem_wdata;
  logic        mem_ack;
  logic [63:0] mem_rdata;
  logic        done;
  logic [1:0]  fault_code;
  logic [39:0] ppn;
  logic [51:0] paddr;

  always #10 clk = ~clk;

  ptw_walker i_ptw_walker (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .idle_o(idle),
    .root_ppn_i(root_ppn), .vaddr_i(vaddr),
    .acc_write_i(acc_w), .acc_user_i(acc_u), .acc_fetch_i(acc_f),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
    .mem_wdata_o(mem_wdata), .mem_ack_i(mem_ack), .mem_rdata_i(mem_rdata),
    .done_o(done), .fault_code_o(fault_code), .ppn_o(ppn), .paddr_o(paddr)
  );

  int n_cmp = 0;
  int n_bad = 0;

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // memory model
  logic [63:0] mem [logic [51:0]];
  logic [51:0] rd_log[$];
  logic [51:0] wr_log[$];
  int          lat_cfg = 1;
  int          lat_cnt;
  logic        pending;
  logic [51:0] p_addr;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_ack   <= 1'b0;
      mem_rdata <= '0;
      pending   <= 1'b0;
      lat_cnt   <= 0;
      p_addr    <= '0;
    end else begin
      mem_ack <= 1'b0;
      if (mem_req) begin
        pending <= 1'b1;
        lat_cnt <= lat_cfg;
        p_addr  <= mem_addr;
        if (mem_we) begin
          mem[mem_addr] = mem_wdata;
          wr_log.push_back(mem_addr);
        end else rd_log.push_back(mem_addr);
      end else if (pending) begin
        if (lat_cnt == 0) begin
          mem_ack   <= 1'b1;
          mem_rdata <= mem.exists(p_addr) ? mem[p_addr] : 64'h0;
          pending   <= 1'b0;
        end else lat_cnt <= lat_cnt - 1;
      end
    end
  end

  function automatic logic [47:0] mk_va(int i0, int i1, int i2, int i3, logic [11:0] off);
    return {i0[8:0], i1[8:0], i2[8:0], i3[8:0], off};
  endfunction

  function automatic logic [8:0] idx_of(logic [47:0] va, int lvl);
    return va[47-9*lvl -: 9];
  endfunction

  function automatic logic [63:0] rd_mem(logic [51:0] a);
    return mem.exists(a) ? mem[a] : 64'h0;
  endfunction

  function automatic logic [51:0] ent_addr(logic [39:0] root, logic [47:0] va, int lvl);
    logic [39:0] base = root;
    for (int l = 0; l < lvl; l++) base = rd_mem({base, idx_of(va, l), 3'b000})[51:12];
    return {base, idx_of(va, lvl), 3'b000};
  endfunction

  logic [39:0] next_tbl = 40'h200;

  task automatic map_page(logic [47:0] va, logic [39:0] leaf_ppn);
    logic [39:0] base = root_ppn;
    logic [51:0] a;
    for (int l = 0; l < 3; l++) begin
      a = {base, idx_of(va, l), 3'b000};
      if (!rd_mem(a)[0]) begin
        mem[a] = {12'h000, next_tbl, 12'h007};
        next_tbl++;
      end
      base = rd_mem(a)[51:12];
    end
    mem[{base, idx_of(va, 3), 3'b000}] = {12'h000, leaf_ppn, 12'h007};
  endtask

  task automatic set_bit(logic [47:0] va, int lvl, int pos, logic val);
    logic [51:0] a = ent_addr(root_ppn, va, lvl);
    logic [63:0] e = rd_mem(a);
    e[pos] = val;
    mem[a] = e;
  endtask

  // scoreboard
  logic [1:0]  exp_code_q[$];
  logic [39:0] exp_ppn_q[$];
  logic [51:0] exp_pa_q[$];
  string       exp_tag_q[$];

  always @(negedge clk) begin
    if (rst_n && done) begin
      if (exp_code_q.size() == 0) begin
        n_cmp++; n_bad++;
        $display("FAIL R10: unexpected done, actual 1 expected 0");
      end else begin
        chk({exp_tag_q[0], " code"}, 64'(fault_code), 64'(exp_code_q[0]));
        chk({exp_tag_q[0], " ppn"},  64'(ppn),        64'(exp_ppn_q[0]));
        chk({exp_tag_q[0], " paddr"}, 64'(paddr),     64'(exp_pa_q[0]));
        void'(exp_code_q.pop_front());
        void'(exp_ppn_q.pop_front());
        void'(exp_pa_q.pop_front());
        void'(exp_tag_q.pop_front());
      end
    end
  end

  task automatic walk(string tag, logic [47:0] va, logic w, logic u, logic f,
                      logic [1:0] ecode, logic [39:0] eppn);
    exp_code_q.push_back(ecode);
    exp_ppn_q.push_back(eppn);
    exp_pa_q.push_back({eppn, va[11:0]});
    exp_tag_q.push_back(tag);
    rd_log.delete();
    wr_log.delete();
    while (!idle) @(negedge clk);
    vaddr = va; acc_w = w; acc_u = u; acc_f = f;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    while (!done) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [47:0] va1, va2, va3, va4, va5, va6, va7;
    logic [51:0] exp_a [4];
    logic [63:0] e;
    root_ppn = 40'h0_0010;
    va1 = mk_va(1, 2, 3, 4, 12'hABC);
    va2 = mk_va(1, 2, 5, 6, 12'h010);
    va3 = mk_va(7, 1, 1, 1, 12'h123);
    va4 = mk_va(9, 0, 0, 0, 12'hFFF);
    va5 = mk_va(11, 3, 3, 3, 12'h000);
    va6 = mk_va(13, 4, 4, 4, 12'h008);
    va7 = mk_va(300, 0, 0, 0, 12'h444);
    map_page(va1, 40'hABCDE);
    map_page(va2, 40'h12345);
    map_page(va3, 40'h00777);
    map_page(va4, 40'h00999);
    map_page(va5, 40'h0BEEF);
    map_page(va6, 40'h0CAFE);
    set_bit(va2, 2, 0, 1'b0);   // not present at level 2
    set_bit(va3, 1, 1, 1'b0);   // read-only at level 1
    set_bit(va4, 0, 2, 1'b0);   // supervisor-only at level 0
    set_bit(va5, 3, 63, 1'b1);  // no-execute at leaf
    set_bit(va6, 0, 63, 1'b1);  // no-execute at level 0

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10 reset idle", 64'(idle), 64'd1);
    chk("R10 reset done", 64'(done), 64'd0);
    chk("R11 reset req",  64'(mem_req), 64'd0);

    // R1 R2 R7: plain read walk
    for (int l = 0; l < 4; l++) exp_a[l] = ent_addr(root_ppn, va1, l);
    lat_cfg = 1;
    walk("R2 read walk", va1, 1'b0, 1'b1, 1'b0, 2'd0, 40'hABCDE);
    chk("R1 read count", 64'(rd_log.size()), 64'd4);
    for (int l = 0; l < 4; l++) begin
      chk("R1 read address", 64'(rd_log[l]), 64'(exp_a[l]));
      chk("R7 accessed set", 64'(rd_mem(exp_a[l])[5]), 64'd1);
      chk("R7 write order", 64'(wr_log[l]), 64'(exp_a[l]));
    end
    chk("R8 no dirty on read", 64'(rd_mem(exp_a[3])[6]), 64'd0);

    // R9: nothing changes on repeat
    lat_cfg = 0;
    walk("R9 repeat walk", va1, 1'b0, 1'b0, 1'b0, 2'd0, 40'hABCDE);
    chk("R9 no write-back", 64'(wr_log.size()), 64'd0);

    // R8: write sets dirty on leaf only
    lat_cfg = 3;
    walk("R8 write walk", va1, 1'b1, 1'b1, 1'b0, 2'd0, 40'hABCDE);
    chk("R8 single write-back", 64'(wr_log.size()), 64'd1);
    chk("R8 leaf dirty", 64'(rd_mem(exp_a[3])[6]), 64'd1);
    for (int l = 0; l < 3; l++) chk("R8 upper clean", 64'(rd_mem(exp_a[l])[6]), 64'd0);

    // R3: not present at level 2 and at level 0
    lat_cfg = 2;
    walk("R3 np level2", va2, 1'b0, 1'b0, 1'b0, 2'd1, 40'h0);
    chk("R3 reads stop", 64'(rd_log.size()), 64'd3);
    chk("R9 fault no write", 64'(wr_log.size()), 64'd0);
    walk("R3 np level0", va7, 1'b0, 1'b0, 1'b0, 2'd1, 40'h0);
    chk("R3 single read", 64'(rd_log.size()), 64'd1);

    // R4: read-only at level 1
    lat_cfg = 1;
    walk("R4 write to ro", va3, 1'b1, 1'b0, 1'b0, 2'd2, 40'h0);
    chk("R9 fault no write", 64'(wr_log.size()), 64'd0);
    e = rd_mem(ent_addr(root_ppn, va3, 0));
    chk("R9 accessed untouched", 64'(e[5]), 64'd0);
    walk("R4 read of ro", va3, 1'b0, 1'b1, 1'b0, 2'd0, 40'h00777);

    // R5: supervisor-only at level 0
    walk("R5 user denied", va4, 1'b0, 1'b1, 1'b0, 2'd2, 40'h0);
    walk("R5 supervisor ok", va4, 1'b1, 1'b0, 1'b0, 2'd0, 40'h00999);

    // R6: no-execute at leaf and at level 0
    lat_cfg = 0;
    walk("R6 fetch leaf nx", va5, 1'b0, 1'b1, 1'b1, 2'd2, 40'h0);
    walk("R6 read leaf nx", va5, 1'b0, 1'b1, 1'b0, 2'd0, 40'h0BEEF);
    walk("R6 fetch top nx", va6, 1'b0, 1'b0, 1'b1, 2'd2, 40'h0);
    walk("R6 fetch ok", va1, 1'b0, 1'b1, 1'b1, 2'd0, 40'hABCDE);

    chk("R10 all walks done", 64'(exp_code_q.size()), 64'd0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule